// File: doc/BRIEF.md
# Streaming Transmit Packet Protocol Monitor

This block sits passively beside a 256-bit transmit packet stream. The stream carries start and end markers, a valid qualifier, a ready back-pressure signal, an empty count on the last beat and an error flag that nullifies a packet. It never drives the stream. On every clock it judges the traffic against a fixed set of rules: framing, the valid window implied by the configured ready latency, how fast valid follows changes in ready, where the nullify flag may appear, and whether each packet has as many beats as its header promises. A wrong beat count would leave the sink stuck, so it is among the rules checked.

Each rule owns one sticky flag that stays set until a synchronous clear pulse. A wrapping counter records every packet that closes with an end beat. The header decode reads only three things from the first beat: the format and type bits, the 10-bit dword length and one address bit.

Top module: `txstream_monitor`

## Requirements
- R1: While rstN is low and after its release, violFlags is all zero and pktCount is zero until traffic sets them. The ready history is also cleared by reset, so the cycles right after reset count as not ready.
- R2: violFlags[0] (framing) is set by a valid beat with txSop high while a packet is open, or by a valid beat with txSop low while no packet is open. A valid beat carrying txSop opens a packet. A valid beat carrying txEop closes the open packet, or the one that txSop opens in the same beat. A restarting sop discards the open packet.
- R3: violFlags[1] (length) is set at a closing end beat whose beat count differs from the expected count. The expected count is taken from the start beat: txData[30] set means the packet has payload; txData[29] set, or txData[28:27]==2'b10 (a message), means a 4-dword header, otherwise 3. The length is txData[9:0], with 0 standing for 1024. A pad dword is added when a 3-dword header has txData[66]==0, or when a 4-dword header has txData[98]==1. With payload the count is ceil((header+pad+length)/8); without payload it is 1.
- R4: violFlags[2] (window) is set by a valid cycle whose txReady, READY_LATENCY cycles earlier (1 or 2, default 2), was low.
- R5: violFlags[3] (late stop) is set by a valid cycle when txReady was low both one and two cycles earlier.
- R6: violFlags[4] (gap) is set when a packet is open, txValid is low, and txReady was high both one and two cycles earlier. A gap that follows a ready drop is legal.
- R7: violFlags[5] (error position) is set when txErr is high in any of these cases: txValid is low; the beat is a start or end beat; no packet is open; or the open packet already carried an error.
- R8: violFlags[6] (short error) is set at the closing end beat of a packet of 1 or 2 beats in which txErr was high on a valid beat.
- R9: violFlags[7] (nullify spacing) is set by a start beat in the cycle right after the end beat of a packet that carried a valid txErr.
- R10: violFlags[8] (empty) is set by a valid beat with txEop low and txEmpty nonzero.
- R11: pktCount rises by one, modulo 2^CNT_W, for each closing end beat and is otherwise unchanged.
- R12: A flag appears in the cycle after the offending cycle and stays set. A cycle with clearFlags high replaces all flags with only the violations found in that same cycle, so a new violation wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clearFlags | input | 1 | Synchronous clear of all sticky flags |
| txData | input | DATA_W (256) | Stream data; header dword 0 in the low 32 bits on a start beat |
| txSop | input | 1 | First beat of a packet |
| txEop | input | 1 | Last beat of a packet |
| txValid | input | 1 | Beat qualifier |
| txReady | input | 1 | Sink ready, applied READY_LATENCY cycles later |
| txEmpty | input | EMPTY_W (2) | Empty quadwords on an end beat |
| txErr | input | 1 | Nullify flag |
| violFlags | output | 9 | Sticky rule flags, bit positions as in R2 to R10 |
| pktCount | output | CNT_W (16) | Closed packet count |

## Verification
A clear pulse and a fresh violation can land in the same cycle. The bench first leaves a length flag standing, then drives a mid-packet beat with no packet open, with clearFlags high in that same cycle. The result is judged correct only if the old flag is gone and the new framing flag survives. The same cycle-level overlap happens when one beat breaks two rules at once, such as an error on the end beat of a two-beat packet. For that case the bench expects both flags from a single beat.

// File: rtl/txmon_pkg.sv
package txmon_pkg;
  localparam int NUM_RULES     = 9;
  localparam int RULE_FRAME    = 0;
  localparam int RULE_LENGTH   = 1;
  localparam int RULE_WINDOW   = 2;
  localparam int RULE_LATESTOP = 3;
  localparam int RULE_GAP      = 4;
  localparam int RULE_ERRPOS   = 5;
  localparam int RULE_ERRSHORT = 6;
  localparam int RULE_NULLSOP  = 7;
  localparam int RULE_EMPTY    = 8;

  typedef struct packed {
    logic                 sopBeat;
    logic                 pktBeat;
    logic                 eopBeat;
    logic                 pktErr;
    logic [NUM_RULES-1:0] viol;
  } mon_strobe_t;
endpackage

// File: rtl/txmon_ctrl.sv
module txmon_ctrl
  import txmon_pkg::*;
#(
  parameter int READY_LATENCY = 2,
  parameter int EMPTY_W       = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               txValid,
  input  logic               txSop,
  input  logic               txEop,
  input  logic               txReady,
  input  logic               txErr,
  input  logic [EMPTY_W-1:0] txEmpty,
  output mon_strobe_t        strobes
);
  logic readyD1, readyD2, readyWin;
  logic pktOpen, errSeen, nullPrev;
  logic sopBeat, pktBeat, eopBeat, pktErr;

  generate
    if (READY_LATENCY == 1) begin : g_lat1
      assign readyWin = readyD1;
    end else begin : g_lat2
      assign readyWin = readyD2;
    end
  endgenerate

  assign sopBeat = txValid & txSop;
  assign pktBeat = txValid & (txSop | pktOpen);
  assign eopBeat = txValid & txEop & (txSop | pktOpen);
  assign pktErr  = (errSeen & ~sopBeat) | (txErr & txValid);

  always_comb begin
    strobes.sopBeat = sopBeat;
    strobes.pktBeat = pktBeat;
    strobes.eopBeat = eopBeat;
    strobes.pktErr  = pktErr;
    strobes.viol    = '0;
    strobes.viol[RULE_FRAME]    = (sopBeat & pktOpen) | (txValid & ~txSop & ~pktOpen);
    strobes.viol[RULE_WINDOW]   = txValid & ~readyWin;
    strobes.viol[RULE_LATESTOP] = txValid & ~readyD1 & ~readyD2;
    strobes.viol[RULE_GAP]      = pktOpen & ~txValid & readyD1 & readyD2;
    strobes.viol[RULE_ERRPOS]   = txErr & (~txValid | txSop | txEop | ~pktOpen | errSeen);
    strobes.viol[RULE_NULLSOP]  = sopBeat & nullPrev;
    strobes.viol[RULE_EMPTY]    = txValid & ~txEop & (txEmpty != '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readyD1  <= 1'b0;
      readyD2  <= 1'b0;
      pktOpen  <= 1'b0;
      errSeen  <= 1'b0;
      nullPrev <= 1'b0;
    end else begin
      readyD1  <= txReady;
      readyD2  <= readyD1;
      nullPrev <= eopBeat & pktErr;
      if (eopBeat) begin
        pktOpen <= 1'b0;
        errSeen <= 1'b0;
      end else if (sopBeat) begin
        pktOpen <= 1'b1;
        errSeen <= txErr;
      end else if (pktOpen) begin
        errSeen <= errSeen | (txErr & txValid);
      end
    end
  end
endmodule

// File: rtl/txmon_datapath.sv
module txmon_datapath
  import txmon_pkg::*;
#(
  parameter int DATA_W = 256,
  parameter int CNT_W  = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 clearFlags,
  input  logic [DATA_W-1:0]    txData,
  input  mon_strobe_t          strobes,
  output logic [NUM_RULES-1:0] violFlags,
  output logic [CNT_W-1:0]     pktCount
);
  localparam int DW_PER_BEAT = DATA_W / 32;
  localparam int BEAT_SHIFT  = $clog2(DW_PER_BEAT);
  localparam int MAX_LEN     = 1024;
  localparam int MAX_TOTAL   = 5 + MAX_LEN;
  localparam int MAX_BEATS   = (MAX_TOTAL + DW_PER_BEAT - 1) / DW_PER_BEAT;
  localparam int BEAT_W      = $clog2(MAX_BEATS + 2);
  localparam int TOT_W       = $clog2(MAX_TOTAL + DW_PER_BEAT + 1);

  function automatic logic [BEAT_W-1:0] hdrBeats(input logic [DATA_W-1:0] d);
    logic             hdr4, pad;
    logic [TOT_W-1:0] len, tot;
    hdr4 = d[29] | (d[28:27] == 2'b10);
    len  = (d[9:0] == 10'd0) ? TOT_W'(MAX_LEN) : TOT_W'(d[9:0]);
    pad  = hdr4 ? d[98] : ~d[66];
    tot  = (hdr4 ? TOT_W'(4) : TOT_W'(3)) + TOT_W'(pad) + len + TOT_W'(DW_PER_BEAT - 1);
    return d[30] ? BEAT_W'(tot >> BEAT_SHIFT) : BEAT_W'(1);
  endfunction

  logic [BEAT_W-1:0]    beatCnt, expReg, cntCur, expCur;
  logic [NUM_RULES-1:0] newViol;
  logic                 unusedData;

  assign unusedData = ^txData;

  always_comb begin
    if (strobes.sopBeat)          cntCur = BEAT_W'(1);
    else if (&beatCnt)            cntCur = beatCnt;
    else                          cntCur = beatCnt + BEAT_W'(1);
    expCur = strobes.sopBeat ? hdrBeats(txData) : expReg;
    newViol = strobes.viol;
    newViol[RULE_LENGTH]   = strobes.eopBeat & (cntCur != expCur);
    newViol[RULE_ERRSHORT] = strobes.eopBeat & strobes.pktErr & (cntCur <= BEAT_W'(2));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      beatCnt   <= '0;
      expReg    <= '0;
      violFlags <= '0;
      pktCount  <= '0;
    end else begin
      if (strobes.pktBeat) beatCnt <= cntCur;
      if (strobes.sopBeat) expReg  <= expCur;
      violFlags <= clearFlags ? newViol : (violFlags | newViol);
      pktCount  <= pktCount + CNT_W'(strobes.eopBeat);
    end
  end
endmodule

// File: rtl/txstream_monitor.sv
module txstream_monitor
  import txmon_pkg::*;
#(
  parameter int DATA_W        = 256,
  parameter int EMPTY_W       = 2,
  parameter int READY_LATENCY = 2,
  parameter int CNT_W         = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 clearFlags,
  input  logic [DATA_W-1:0]    txData,
  input  logic                 txSop,
  input  logic                 txEop,
  input  logic                 txValid,
  input  logic                 txReady,
  input  logic [EMPTY_W-1:0]   txEmpty,
  input  logic                 txErr,
  output logic [NUM_RULES-1:0] violFlags,
  output logic [CNT_W-1:0]     pktCount
);
  mon_strobe_t strobes;

  txmon_ctrl #(.READY_LATENCY(READY_LATENCY), .EMPTY_W(EMPTY_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .txValid(txValid), .txSop(txSop), .txEop(txEop),
    .txReady(txReady), .txErr(txErr), .txEmpty(txEmpty), .strobes(strobes)
  );

  txmon_datapath #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .clearFlags(clearFlags), .txData(txData),
    .strobes(strobes), .violFlags(violFlags), .pktCount(pktCount)
  );
endmodule

// File: rtl/txstream_monitor_chk.sv
module txstream_monitor_chk
  import txmon_pkg::*;
#(
  parameter int DATA_W        = 256,
  parameter int EMPTY_W       = 2,
  parameter int READY_LATENCY = 2,
  parameter int CNT_W         = 16
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 clearFlags,
  input logic [DATA_W-1:0]    txData,
  input logic                 txSop,
  input logic                 txEop,
  input logic                 txValid,
  input logic                 txReady,
  input logic [EMPTY_W-1:0]   txEmpty,
  input logic                 txErr,
  input logic [NUM_RULES-1:0] violFlags,
  input logic [CNT_W-1:0]     pktCount
);
  logic unusedChk;
  assign unusedChk = ^{txData, txSop, txErr};

  // R4
  window_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && ((READY_LATENCY == 1) ? !$past(txReady) : !$past(txReady, 2)))
    |=> violFlags[RULE_WINDOW]);

  // R5
  late_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !$past(txReady) && !$past(txReady, 2)) |=> violFlags[RULE_LATESTOP]);

  // R10
  empty_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txEop && (txEmpty != '0)) |=> violFlags[RULE_EMPTY]);

  // R11
  count_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(txValid && txEop) |=> $stable(pktCount));

  // R12
  sticky_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    !clearFlags |=> ((violFlags & $past(violFlags)) == $past(violFlags)));
endmodule

bind txstream_monitor txstream_monitor_chk #(
  .DATA_W(DATA_W), .EMPTY_W(EMPTY_W), .READY_LATENCY(READY_LATENCY), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rstN(rstN), .clearFlags(clearFlags), .txData(txData), .txSop(txSop),
  .txEop(txEop), .txValid(txValid), .txReady(txReady), .txEmpty(txEmpty),
  .txErr(txErr), .violFlags(violFlags), .pktCount(pktCount)
);

// File: tb/txstream_monitor_tb.sv
`timescale 1ns/1ps
module txstream_monitor_tb;
  localparam int RL = 2;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         clearFlags = 1'b0;
  logic [255:0] txData = '0;
  logic         txSop = 1'b0, txEop = 1'b0, txValid = 1'b0, txReady = 1'b1, txErr = 1'b0;
  logic [1:0]   txEmpty = '0;
  logic [8:0]   violFlags;
  logic [15:0]  pktCount;

  int compared = 0, mismatched = 0, cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  txstream_monitor u_dut (
    .clk(clk), .rstN(rstN), .clearFlags(clearFlags), .txData(txData), .txSop(txSop),
    .txEop(txEop), .txValid(txValid), .txReady(txReady), .txEmpty(txEmpty),
    .txErr(txErr), .violFlags(violFlags), .pktCount(pktCount)
  );

  // behavioural reference state
  bit     h1, h2, mOpen, mErr, mNull;
  bit [8:0] mFlags;
  integer mCnt, mExp, mPkts;

  function automatic string reqOf(int b);
    string names [9] = '{"R2", "R3", "R4", "R5", "R6", "R7", "R8", "R9", "R10"};
    return names[b];
  endfunction

  function automatic integer expBeats(logic [255:0] d);
    integer hdr, len, pad;
    if (!d[30]) return 1;
    hdr = (d[29] || d[28:27] == 2'b10) ? 4 : 3;
    len = (d[9:0] == 0) ? 1024 : integer'(d[9:0]);
    pad = (hdr == 4) ? integer'(d[98]) : integer'(!d[66]);
    return (hdr + pad + len + 7) / 8;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      h1 = 0; h2 = 0; mOpen = 0; mErr = 0; mNull = 0; mFlags = '0;
      mCnt = 0; mExp = 0; mPkts = 0;
    end else begin
      bit win, sopB, beatB, eopB, pe;
      bit [8:0] v;
      v = '0;
      win   = (RL == 1) ? h1 : h2;
      sopB  = txValid && txSop;
      beatB = txValid && (txSop || mOpen);
      eopB  = txValid && txEop && (txSop || mOpen);
      if ((sopB && mOpen) || (txValid && !txSop && !mOpen)) v[0] = 1;
      if (txValid && !win) v[2] = 1;
      if (txValid && !h1 && !h2) v[3] = 1;
      if (mOpen && !txValid && h1 && h2) v[4] = 1;
      if (txErr && (!txValid || txSop || txEop || !mOpen || mErr)) v[5] = 1;
      if (sopB && mNull) v[7] = 1;
      if (txValid && !txEop && txEmpty != 0) v[8] = 1;
      pe = (sopB ? 1'b0 : mErr) || (txErr && txValid);
      if (sopB) begin mExp = expBeats(txData); mCnt = 1; end
      else if (beatB) mCnt = mCnt + 1;
      if (eopB) begin
        if (mCnt != mExp) v[1] = 1;
        if (pe && mCnt <= 2) v[6] = 1;
        mPkts = mPkts + 1;
      end
      mNull = eopB && pe;
      if (eopB) mErr = 0;
      else if (sopB) mErr = txErr;
      else if (mOpen) mErr = mErr || (txErr && txValid);
      if (eopB) mOpen = 0; else if (sopB) mOpen = 1;
      mFlags = clearFlags ? v : (mFlags | v);
      h2 = h1; h1 = txReady;
    end
  end

  // compare against the reference every cycle
  always @(negedge clk) begin
    if (rstN && !done) begin
      for (int b = 0; b < 9; b++) begin
        compared++;
        if (violFlags[b] !== mFlags[b]) begin
          mismatched++;
          $display("FAIL %s flag bit %0d: actual %0b expected %0b (cycle %0d)",
                   reqOf(b), b, violFlags[b], mFlags[b], cyc);
        end
      end
      compared++;
      if (pktCount !== 16'(mPkts)) begin
        mismatched++;
        $display("FAIL R11 pktCount: actual %0d expected %0d (cycle %0d)", pktCount, 16'(mPkts), cyc);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic drive(input logic v, s, e, er, input logic [1:0] em,
                       input logic [255:0] d, input logic rdy, clr);
    @(negedge clk);
    txValid = v; txSop = s; txEop = e; txErr = er; txEmpty = em;
    txData = d; txReady = rdy; clearFlags = clr;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 2'd0, '0, 1, 0);
  endtask

  task automatic clr();
    drive(0, 0, 0, 0, 2'd0, '0, 1, 1);
  endtask

  task automatic checkFlags(input logic [8:0] mask, input logic [15:0] cnt, input string tag);
    @(negedge clk);
    compared++;
    if (violFlags !== mask) begin
      mismatched++;
      $display("FAIL %s flags: actual %03h expected %03h", tag, violFlags, mask);
    end
    compared++;
    if (pktCount !== cnt) begin
      mismatched++;
      $display("FAIL %s pktCount: actual %0d expected %0d", tag, pktCount, cnt);
    end
    txValid = 0; txSop = 0; txEop = 0; txErr = 0; txEmpty = 0; txData = '0;
    txReady = 1; clearFlags = 0;
  endtask

  function automatic logic [255:0] hdr(input bit fmt4, hasData, isMsg,
                                       input int len, input bit addrBit);
    logic [255:0] d;
    d = '0;
    d[30] = hasData;
    d[29] = fmt4;
    d[28:24] = isMsg ? 5'b10000 : 5'b00000;
    d[9:0] = 10'(len);
    d[66] = addrBit;
    d[98] = addrBit;
    return d;
  endfunction

  task automatic sendPkt(input logic [255:0] d, input int n, input int errAt,
                         input logic [1:0] emSop, emEop);
    for (int i = 0; i < n; i++) begin
      logic [1:0] em;
      em = (i == n - 1) ? emEop : ((i == 0) ? emSop : 2'd0);
      drive(1, i == 0, i == n - 1, i == errAt, em, (i == 0) ? d : {8{32'hA5A5_0000 + i}}, 1, 0);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    idle(3);
    checkFlags(9'h000, 16'd0, "R1 after reset");

    sendPkt(hdr(0, 1, 0, 16, 0), 3, -1, 0, 2'd3);
    checkFlags(9'h000, 16'd1, "R3 len16 aligned 3 beats");
    sendPkt(hdr(0, 1, 0, 5, 0), 1, -1, 0, 0);
    checkFlags(9'h002, 16'd2, "R3 len5 aligned in 1 beat");
    clr();
    checkFlags(9'h000, 16'd2, "R12 clear");

    sendPkt(hdr(0, 1, 0, 5, 1), 1, -1, 0, 0);
    sendPkt(hdr(1, 1, 0, 4, 1), 2, -1, 0, 0);
    sendPkt(hdr(1, 1, 0, 4, 0), 1, -1, 0, 0);
    sendPkt(hdr(0, 0, 0, 4, 0), 1, -1, 0, 0);
    sendPkt(hdr(0, 1, 1, 4, 0), 1, -1, 0, 0);
    sendPkt(hdr(0, 1, 0, 0, 0), 129, -1, 0, 0);
    checkFlags(9'h000, 16'd8, "R3 R11 expected beat counts");

    drive(1, 0, 0, 0, 0, '0, 1, 0);
    checkFlags(9'h001, 16'd8, "R2 beat with no packet open");
    clr();
    drive(1, 1, 0, 0, 0, hdr(0, 1, 0, 16, 0), 1, 0);
    sendPkt(hdr(0, 1, 0, 16, 0), 3, -1, 0, 0);
    checkFlags(9'h001, 16'd9, "R2 sop while open");
    clr();

    sendPkt(hdr(0, 1, 0, 16, 0), 3, -1, 2'd1, 2'd2);
    checkFlags(9'h100, 16'd10, "R10 empty outside eop");
    clr();

    drive(0, 0, 0, 0, 0, '0, 0, 0);
    drive(0, 0, 0, 0, 0, '0, 1, 0);
    drive(1, 1, 1, 0, 0, hdr(0, 0, 0, 1, 0), 1, 0);
    checkFlags(9'h004, 16'd11, "R4 valid outside window");
    clr();
    idle(1);

    drive(0, 0, 0, 0, 0, '0, 0, 0);
    drive(0, 0, 0, 0, 0, '0, 0, 0);
    drive(1, 1, 1, 0, 0, hdr(0, 0, 0, 1, 0), 1, 0);
    checkFlags(9'h00C, 16'd12, "R5 valid after long ready drop");
    clr();
    idle(1);

    drive(1, 1, 0, 0, 0, hdr(0, 1, 0, 16, 0), 1, 0);
    drive(0, 0, 0, 0, 0, '0, 1, 0);
    drive(0, 0, 0, 0, 0, '0, 1, 0);
    drive(1, 0, 0, 0, 0, '1, 1, 0);
    drive(1, 0, 1, 0, 0, '1, 1, 0);
    checkFlags(9'h010, 16'd13, "R6 gap with ready high");
    clr();
    idle(1);

    drive(1, 1, 0, 0, 0, hdr(0, 1, 0, 16, 0), 1, 0);
    drive(1, 0, 0, 0, 0, '1, 0, 0);
    drive(0, 0, 0, 0, 0, '0, 0, 0);
    drive(0, 0, 0, 0, 0, '0, 1, 0);
    drive(0, 0, 0, 0, 0, '0, 1, 0);
    drive(1, 0, 1, 0, 0, '1, 1, 0);
    checkFlags(9'h000, 16'd14, "R6 R4 legal pause after ready drop");

    sendPkt(hdr(0, 1, 0, 16, 0), 3, 1, 0, 0);
    checkFlags(9'h000, 16'd15, "R7 R9 legal nullify with spacing");
    sendPkt(hdr(0, 1, 0, 16, 0), 3, 1, 0, 0);
    sendPkt(hdr(0, 0, 0, 1, 0), 1, -1, 0, 0);
    checkFlags(9'h080, 16'd17, "R9 sop right after nullified eop");
    clr();

    sendPkt(hdr(0, 1, 0, 16, 0), 3, 0, 0, 0);
    checkFlags(9'h020, 16'd18, "R7 err on sop beat");
    clr();
    drive(0, 0, 0, 1, 0, '0, 1, 0);
    checkFlags(9'h020, 16'd18, "R7 err without valid or packet");
    clr();

    sendPkt(hdr(1, 1, 0, 4, 1), 2, 1, 0, 0);
    checkFlags(9'h060, 16'd19, "R8 err on 2-beat packet");
    clr();

    sendPkt(hdr(0, 1, 0, 5, 0), 1, -1, 0, 0);
    drive(0, 0, 0, 0, 0, '0, 1, 0);
    drive(1, 0, 0, 0, 0, '0, 1, 1);
    checkFlags(9'h001, 16'd20, "R12 new violation wins over clear");
    idle(3);
    checkFlags(9'h001, 16'd20, "R12 flag stays sticky");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule